// File: doc/BRIEF.md
# Programmable raster timing counter

This block turns a pixel clock into the basic timing skeleton of a video raster. A horizontal position counter walks across each line and a vertical position counter walks down each frame. Both lengths, and the porch, sync and blanking edges on each axis, come from 12-bit timing words presented on static input ports. Comparators against those words produce raw active-high horizontal and vertical sync and blank strobes, a field flag, and a one-clock strobe at the middle of each line. Polarity, output muxing and composite-sync shaping belong to logic downstream.

Positions are 1-based. A line lasts `h_total` clocks, and a frame lasts `v_total` whole lines in both scan modes. With interlace on, the vertical position counts half-lines within a field. Each field is `v_total` half-lines long, so an odd `v_total` makes the second field begin in mid-line. The vertical porch, sync and blank words are then read in half-line units. The vertical blank strobe moves only when the vertical position moves, which is at the start of horizontal blank, or at mid-line in interlace. The vertical sync strobe is re-evaluated only where horizontal sync begins, and in interlace also half a line later.

All timing words are captured into a shadow copy at start-up and at each frame boundary, so a change on the ports never disturbs a frame in progress. Every register in the block is clocked on the falling edge of `clk`. `en` gates every state change. `clr` clears everything asynchronously, and the first enabled falling edge after a clear starts a frame.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, `h_pos` goes 1, 2, …, `h_total` and then back to 1, so each line lasts `h_total` enabled clocks.
- R2: `hblank` is high exactly while `h_pos` < `h_blank_end`. `hsync` is high exactly while `h_fp_end` ≤ `h_pos` < `h_sync_end`.
- R3: `half_line` is high for exactly the clock where `h_pos` equals `h_total`/2, rounded down. `cfg_err` is high while the captured `h_total` is odd.
- R4: With `interlace`=0, `v_pos` advances when `h_pos` returns to 1 and runs 1…`v_total`. `vblank` is high exactly while `v_pos` < `v_blank_end`.
- R5: With `interlace`=1, `v_pos` advances both when `h_pos` becomes 1 and when it becomes `h_total`/2+1. It runs 1…`v_total` within each field. `odd_field` is 1 in the first field of a frame and 0 in the second, and a frame lasts `h_total`·`v_total` clocks.
- R6: `vblank` changes only on a clock where `v_pos` takes a new value. `vsync` takes the value (`v_fp_end` ≤ `v_pos` < `v_sync_end`) only on clocks where `h_pos` becomes `h_fp_end`, or `h_fp_end`+`h_total`/2 in interlace, or a frame starts after clear. Otherwise it holds.
- R7: `odd_field` is held at 1 whenever non-interlaced scanning is in effect.
- R8: While `en` is 0 no position, strobe or flag changes.
- R9: `clr`=1 forces `h_pos`=0, `v_pos`=0, all strobes to 0, `cfg_err`=0 and `odd_field`=1. The first enabled falling edge after release gives `h_pos`=1 and `v_pos`=1.
- R10: Timing inputs are captured only at the first start after clear and at a frame boundary. A port change mid-frame takes effect with the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; state changes on its falling edge |
| clr | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Clock enable for all counting |
| interlace | input | 1 | 1 selects interlaced scanning |
| h_fp_end | input | 12 | Horizontal position where sync begins |
| h_sync_end | input | 12 | Horizontal position where sync ends |
| h_blank_end | input | 12 | Horizontal position where blank ends |
| h_total | input | 12 | Clocks per line (even) |
| v_fp_end | input | 12 | Vertical position where vertical sync begins |
| v_sync_end | input | 12 | Vertical position where vertical sync ends |
| v_blank_end | input | 12 | Vertical position where vertical blank ends |
| v_total | input | 12 | Whole lines per frame |
| h_pos | output | 12 | Current horizontal position, 0 when cleared |
| v_pos | output | 12 | Current vertical position (lines or half-lines) |
| hblank | output | 1 | Horizontal blank strobe |
| hsync | output | 1 | Horizontal sync strobe |
| vblank | output | 1 | Vertical blank strobe |
| vsync | output | 1 | Vertical sync strobe |
| odd_field | output | 1 | High in the odd field or when non-interlaced |
| half_line | output | 1 | One-clock strobe at mid-line |
| cfg_err | output | 1 | Captured line length is odd |

## Verification
Every output is compared on every clock against closed-form positions derived from the elapsed clock count. The run covers whole frames in a progressive setting, an interlaced setting with an odd frame length, and a setting with an odd line length. The progressive run separates line-rate from half-line-rate vertical stepping. The interlaced run exposes field toggling, the mid-line field start and the mid-line vsync update point. A line-length change issued mid-frame, an enable drop and a mid-run clear show that capture waits for the frame boundary, that the freeze is complete, and that the block restarts from position 1.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int TW = 12;

  typedef struct packed {
    logic          ilace;
    logic [TW-1:0] h_fp;
    logic [TW-1:0] h_se;
    logic [TW-1:0] h_be;
    logic [TW-1:0] h_tot;
    logic [TW-1:0] v_fp;
    logic [TW-1:0] v_se;
    logic [TW-1:0] v_be;
    logic [TW-1:0] v_tot;
  } raster_cfg_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
  import raster_pkg::*;
(
  input  logic           clk,
  input  logic           clr,
  input  logic           en,
  input  logic           restart,
  input  raster_cfg_t    cfg_cur,
  input  raster_cfg_t    cfg_nx,
  output logic [TW-1:0]  h_pos,
  output logic           hblank,
  output logic           hsync,
  output logic           half_line,
  output logic           line_end,
  output logic           mid_line,
  output logic           sync_edge_nx
);
  logic [TW-1:0] h_nx;
  logic [TW-1:0] half_nx;

  assign line_end = (h_pos == cfg_cur.h_tot);
  assign mid_line = (h_pos == (cfg_cur.h_tot >> 1));
  assign h_nx     = (restart || line_end) ? TW'(1) : h_pos + 1'b1;
  assign half_nx  = cfg_nx.h_tot >> 1;

  // next position lands on a point where vertical sync is re-evaluated
  assign sync_edge_nx = (h_nx == cfg_nx.h_fp) ||
                        (cfg_nx.ilace && (h_nx == cfg_nx.h_fp + half_nx));

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      h_pos     <= '0;
      hblank    <= 1'b0;
      hsync     <= 1'b0;
      half_line <= 1'b0;
    end else if (en) begin
      h_pos     <= h_nx;
      hblank    <= (h_nx < cfg_nx.h_be);
      hsync     <= (h_nx >= cfg_nx.h_fp) && (h_nx < cfg_nx.h_se);
      half_line <= (h_nx == half_nx);
    end
  end
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
(
  input  logic           clk,
  input  logic           clr,
  input  logic           en,
  input  logic           restart,
  input  logic           line_end,
  input  logic           mid_line,
  input  logic           sync_edge_nx,
  input  raster_cfg_t    cfg_cur,
  input  raster_cfg_t    cfg_nx,
  output logic [TW-1:0]  v_pos,
  output logic           vblank,
  output logic           vsync,
  output logic           odd_field,
  output logic           frame_end
);
  logic          step;
  logic          field_end;
  logic [TW-1:0] v_nx;
  logic          odd_nx;

  assign field_end = (v_pos == cfg_cur.v_tot);
  // half-line stepping in interlace, whole-line stepping otherwise
  assign step      = line_end || (cfg_cur.ilace && mid_line);
  assign frame_end = line_end && field_end && (!cfg_cur.ilace || !odd_field);

  always_comb begin
    if (restart)       v_nx = TW'(1);
    else if (step)     v_nx = field_end ? TW'(1) : v_pos + 1'b1;
    else               v_nx = v_pos;

    if (restart || frame_end || !cfg_nx.ilace) odd_nx = 1'b1;
    else if (step && field_end)                 odd_nx = ~odd_field;
    else                                        odd_nx = odd_field;
  end

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      v_pos     <= '0;
      vblank    <= 1'b0;
      vsync     <= 1'b0;
      odd_field <= 1'b1;
    end else if (en) begin
      v_pos     <= v_nx;
      odd_field <= odd_nx;
      vblank    <= (v_nx < cfg_nx.v_be);
      if (restart || sync_edge_nx)
        vsync <= (v_nx >= cfg_nx.v_fp) && (v_nx < cfg_nx.v_se);
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic           clk,
  input  logic           clr,
  input  logic           en,
  input  logic           interlace,
  input  logic [TW-1:0]  h_fp_end,
  input  logic [TW-1:0]  h_sync_end,
  input  logic [TW-1:0]  h_blank_end,
  input  logic [TW-1:0]  h_total,
  input  logic [TW-1:0]  v_fp_end,
  input  logic [TW-1:0]  v_sync_end,
  input  logic [TW-1:0]  v_blank_end,
  input  logic [TW-1:0]  v_total,
  output logic [TW-1:0]  h_pos,
  output logic [TW-1:0]  v_pos,
  output logic           hblank,
  output logic           hsync,
  output logic           vblank,
  output logic           vsync,
  output logic           odd_field,
  output logic           half_line,
  output logic           cfg_err
);
  raster_cfg_t cfg_in, cfg_q, cfg_nx;
  logic        running, restart, frame_end;
  logic        line_end, mid_line, sync_edge_nx;

  assign cfg_in  = '{ilace: interlace, h_fp: h_fp_end, h_se: h_sync_end,
                     h_be: h_blank_end, h_tot: h_total, v_fp: v_fp_end,
                     v_se: v_sync_end, v_be: v_blank_end, v_tot: v_total};
  assign restart = !running;
  assign cfg_nx  = (restart || frame_end) ? cfg_in : cfg_q;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      running <= 1'b0;
      cfg_q   <= '0;
      cfg_err <= 1'b0;
    end else if (en) begin
      running <= 1'b1;
      cfg_q   <= cfg_nx;
      cfg_err <= cfg_nx.h_tot[0];
    end
  end

  raster_hcount u_h (
    .clk(clk), .clr(clr), .en(en), .restart(restart),
    .cfg_cur(cfg_q), .cfg_nx(cfg_nx),
    .h_pos(h_pos), .hblank(hblank), .hsync(hsync), .half_line(half_line),
    .line_end(line_end), .mid_line(mid_line), .sync_edge_nx(sync_edge_nx)
  );

  raster_vcount u_v (
    .clk(clk), .clr(clr), .en(en), .restart(restart),
    .line_end(line_end), .mid_line(mid_line), .sync_edge_nx(sync_edge_nx),
    .cfg_cur(cfg_q), .cfg_nx(cfg_nx),
    .v_pos(v_pos), .vblank(vblank), .vsync(vsync),
    .odd_field(odd_field), .frame_end(frame_end)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
(
  input logic           clk,
  input logic           clr,
  input logic           en,
  input logic           ilace_q,
  input logic [TW-1:0]  h_tot_q,
  input logic [TW-1:0]  h_fp_q,
  input logic [TW-1:0]  h_pos,
  input logic [TW-1:0]  v_pos,
  input logic           hsync,
  input logic           vblank,
  input logic           vsync,
  input logic           odd_field
);
  p_hcount_step_r1: assert property (@(negedge clk) disable iff (clr)
    (en && h_pos != '0 && h_pos != h_tot_q) |=> (h_pos == $past(h_pos) + 1'b1));

  p_hcount_wrap_r1: assert property (@(negedge clk) disable iff (clr)
    (en && h_pos != '0 && h_pos == h_tot_q) |=> (h_pos == TW'(1)));

  p_freeze_r8: assert property (@(negedge clk) disable iff (clr)
    !en |=> ($stable(h_pos) && $stable(v_pos) && $stable(hsync) && $stable(vsync)));

  p_vblank_moves_r6: assert property (@(negedge clk) disable iff (clr)
    !$stable(vblank) |-> (h_pos == TW'(1) ||
                          (ilace_q && h_pos == (h_tot_q >> 1) + 1'b1)));

  p_vsync_moves_r6: assert property (@(negedge clk) disable iff (clr)
    !$stable(vsync) |-> (h_pos == h_fp_q || $past(h_pos) == '0 ||
                         (ilace_q && h_pos == h_fp_q + (h_tot_q >> 1))));

  p_odd_progressive_r7: assert property (@(negedge clk) disable iff (clr)
    (h_pos != '0 && !ilace_q) |-> odd_field);
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk(clk), .clr(clr), .en(en),
  .ilace_q(cfg_q.ilace), .h_tot_q(cfg_q.h_tot), .h_fp_q(cfg_q.h_fp),
  .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vblank(vblank),
  .vsync(vsync), .odd_field(odd_field)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  import raster_pkg::*;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  logic interlace = 1'b0;
  logic [TW-1:0] h_fp_end = '0, h_sync_end = '0, h_blank_end = '0, h_total = '0;
  logic [TW-1:0] v_fp_end = '0, v_sync_end = '0, v_blank_end = '0, v_total = '0;
  logic [TW-1:0] h_pos, v_pos;
  logic hblank, hsync, vblank, vsync, odd_field, half_line, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_il, m_hfp, m_hse, m_hbe, m_ht, m_vfp, m_vse, m_vbe, m_vt;

  always #10 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .clr(clr), .en(en), .interlace(interlace),
    .h_fp_end(h_fp_end), .h_sync_end(h_sync_end), .h_blank_end(h_blank_end),
    .h_total(h_total), .v_fp_end(v_fp_end), .v_sync_end(v_sync_end),
    .v_blank_end(v_blank_end), .v_total(v_total),
    .h_pos(h_pos), .v_pos(v_pos), .hblank(hblank), .hsync(hsync),
    .vblank(vblank), .vsync(vsync), .odd_field(odd_field),
    .half_line(half_line), .cfg_err(cfg_err)
  );

  task automatic drive_cfg(int il, int hfp, int hse, int hbe, int ht,
                           int vfp, int vse, int vbe, int vt);
    interlace = il[0];
    h_fp_end = TW'(hfp); h_sync_end = TW'(hse); h_blank_end = TW'(hbe); h_total = TW'(ht);
    v_fp_end = TW'(vfp); v_sync_end = TW'(vse); v_blank_end = TW'(vbe); v_total = TW'(vt);
  endtask

  task automatic take_model;
    m_il = int'(interlace);
    m_hfp = int'(h_fp_end); m_hse = int'(h_sync_end); m_hbe = int'(h_blank_end); m_ht = int'(h_total);
    m_vfp = int'(v_fp_end); m_vse = int'(v_sync_end); m_vbe = int'(v_blank_end); m_vt = int'(v_total);
  endtask

  function automatic int e_h(int t);
    return t % m_ht + 1;
  endfunction

  function automatic int e_v(int t);
    int span = (m_il != 0) ? m_ht / 2 : m_ht;
    return (t / span) % m_vt + 1;
  endfunction

  function automatic int e_odd(int t);
    if (m_il == 0) return 1;
    return (((t / (m_ht / 2)) / m_vt) % 2 == 0) ? 1 : 0;
  endfunction

  function automatic int e_vsync(int t);
    int s = t;
    while (s > 0) begin
      if (e_h(s) == m_hfp || (m_il != 0 && e_h(s) == m_hfp + m_ht / 2)) break;
      s--;
    end
    return (e_v(s) >= m_vfp && e_v(s) < m_vse) ? 1 : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(int t);
    string vreq = (m_il != 0) ? "R5" : "R4";
    int h = e_h(t);
    chk("R1", "h_pos", int'(h_pos), h);
    chk(vreq, "v_pos", int'(v_pos), e_v(t));
    chk("R2", "hblank", int'(hblank), (h < m_hbe) ? 1 : 0);
    chk("R2", "hsync", int'(hsync), (h >= m_hfp && h < m_hse) ? 1 : 0);
    chk("R3", "half_line", int'(half_line), (h == m_ht / 2) ? 1 : 0);
    chk("R3", "cfg_err", int'(cfg_err), m_ht % 2);
    chk(vreq, "vblank", int'(vblank), (e_v(t) < m_vbe) ? 1 : 0);
    chk("R6", "vsync", int'(vsync), e_vsync(t));
    chk((m_il != 0) ? "R5" : "R7", "odd_field", int'(odd_field), e_odd(t));
  endtask

  task automatic check_cleared;
    chk("R9", "h_pos clear", int'(h_pos), 0);
    chk("R9", "v_pos clear", int'(v_pos), 0);
    chk("R9", "strobes clear", int'({hblank, hsync, vblank, vsync, half_line, cfg_err}), 0);
    chk("R9", "odd clear", int'(odd_field), 1);
  endtask

  task automatic run(int from, int cycles);
    for (int t = from; t < from + cycles; t++) begin
      @(posedge clk);
      check_state(t);
    end
  endtask

  task automatic start_after_clear;
    @(posedge clk);
    clr = 1'b0;
    en  = 1'b1;
  endtask

  initial begin
    // progressive setting
    drive_cfg(0, 3, 5, 7, 10, 2, 3, 4, 6);
    take_model();
    repeat (3) @(posedge clk);
    check_cleared();
    start_after_clear();
    run(0, 120);

    // R10: mid-frame change held until the frame boundary
    for (int t = 0; t < 60; t++) begin
      @(posedge clk);
      check_state(t);
      if (t == 5) drive_cfg(0, 3, 5, 8, 12, 2, 3, 4, 6);
    end
    take_model();
    run(0, 20);

    // R8: enable low freezes everything
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      check_state(19);
    end
    en = 1'b1;
    run(20, 72 - 20 + 72);

    // R9: clear mid-run, then interlaced setting with odd frame length (R5)
    #3 clr = 1'b1;
    drive_cfg(1, 2, 4, 5, 8, 2, 4, 5, 5);
    take_model();
    @(posedge clk);
    check_cleared();
    start_after_clear();
    run(0, 120);

    // R3: odd line length flagged
    clr = 1'b1;
    drive_cfg(0, 2, 4, 6, 9, 2, 3, 3, 6);
    take_model();
    @(posedge clk);
    check_cleared();
    start_after_clear();
    run(0, 54);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule